// File: doc/BRIEF.md
# Power Stage Enable and Protection Supervisor

This block decides when the gate sequencer of a synchronous buck power stage may switch. It watches the control supply level, an active-low disable pin, and a digital die-temperature code, and from them produces a single sequencer enable. The supply check has hysteresis. The check can take a supply code, with a 10 mV least significant bit, or a pair of comparator flags, and a parameter selects which. Whenever the disable pin returns high, a calibration interval of a set number of clock cycles runs before the enable is granted. During that interval the sequencer stays off and PWM activity is ignored.

Temperature is compared against two independent hysteretic thresholds. The lower one only drives an active-low warning flag. The higher one forces a shutdown. After a shutdown ends, the stage comes back without a new calibration, provided the calibration had already completed. On every rising edge of the enable, the sequencer receives a one-cycle start pulse so that it can apply its prebias-safe startup rules. A supply dropout throws away the completed calibration. A shutdown does not.

Top module: `pwr_stage_supervisor`

## Requirements
- R1: While `rst` is high and on the cycle after it, `seq_en`, `seq_start` and `cal_busy` are 0 and `therm_warn_n` is 1.
- R2: In code mode (default), supply is judged good once `supply_code` >= 435 and stays good until `supply_code` < 415; codes in between keep the prior judgement. While supply is not good, `seq_en` is 0 whatever `dis_n` is.
- R3: While `dis_n` is 0, `seq_en` is 0.
- R4: When supply is good, `dis_n` is 1, there is no shutdown and calibration is not complete, `cal_busy` is 1 for exactly CAL_CYCLES (default 25) consecutive cycles with `seq_en` 0. After that, `seq_en` becomes 1 and `cal_busy` becomes 0.
- R5: After each return of `dis_n` from 0 to 1, a full calibration runs again before `seq_en` rises.
- R6: `seq_start` is 1 for exactly one cycle, on the first cycle of each period where `seq_en` is 1.
- R7: `therm_warn_n` goes to 0 when `temp_code` (unsigned degrees C) >= 150 and returns to 1 only when `temp_code` < 135. The warning alone never clears `seq_en`.
- R8: Shutdown begins when `temp_code` > 180 and forces `seq_en` to 0. It ends only when `temp_code` < 155.
- R9: A supply loss or a shutdown during calibration aborts it. When the conditions return, a full CAL_CYCLES calibration runs again.
- R10: When a shutdown ends after calibration completed, `seq_en` returns without calibration and with a `seq_start` pulse. A supply loss clears a completed calibration, so the next enable calibrates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_code | input | SUPPLY_W | Control supply level, 10 mV per LSB (code mode) |
| sup_above_rise | input | 1 | Supply above the release comparator (flag mode) |
| sup_above_fall | input | 1 | Supply above the re-lock comparator (flag mode) |
| dis_n | input | 1 | Active-low disable pin level |
| temp_code | input | TEMP_W | Die temperature in degrees C, unsigned |
| seq_en | output | 1 | Enable to the gate sequencer |
| seq_start | output | 1 | One-cycle pulse on each rise of seq_en |
| cal_busy | output | 1 | Calibration interval in progress |
| therm_warn_n | output | 1 | Active-low thermal warning |

## Verification
Each input passes through one input register and one output register. A change applied between edges is therefore visible on the outputs after the second rising edge that follows it. The exception is the calibration path, where `seq_en` and `seq_start` rise CAL_CYCLES+2 edges after the enabling change, and `cal_busy` is high from the second through the (CAL_CYCLES+1)-th edge. The bench drives inputs on falling edges and waits an exact count of rising edges before sampling at the next falling edge. It checks both the last cycle before each expected change and the cycle of the change, so an off-by-one in either direction shows up. Hysteresis bands are covered by values inside each band, on each side of it, and exactly on each threshold.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Next value of a hysteretic flag: set on set_c when clear, clear on clr_c when set.
  function automatic logic hyst_next(input logic cur, input logic set_c, input logic clr_c);
    return cur ? !clr_c : set_c;
  endfunction

endpackage

// File: rtl/pss_uv_monitor.sv
module pss_uv_monitor #(
  parameter int SUPPLY_W  = 10,
  parameter bit USE_FLAGS = 1'b0,
  parameter int UV_SET    = 435,
  parameter int UV_CLR    = 415
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SUPPLY_W-1:0] supply_code,
  input  logic                above_rise,
  input  logic                above_fall,
  output logic                good
);
  import pss_pkg::*;

  localparam logic [SUPPLY_W-1:0] SET_C = SUPPLY_W'(UV_SET);
  localparam logic [SUPPLY_W-1:0] CLR_C = SUPPLY_W'(UV_CLR);

  logic set_c, clr_c;

  generate
    if (USE_FLAGS) begin : g_flags
      logic unused_code;
      assign unused_code = ^supply_code;
      assign set_c = above_rise;
      assign clr_c = !above_fall;
    end else begin : g_code
      logic unused_flags;
      assign unused_flags = above_rise ^ above_fall;
      assign set_c = (supply_code >= SET_C);
      assign clr_c = (supply_code <  CLR_C);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) good <= 1'b0;
    else     good <= hyst_next(good, set_c, clr_c);
  end
endmodule

// File: rtl/pss_thermal_monitor.sv
module pss_thermal_monitor #(
  parameter int TEMP_W   = 9,
  parameter int WARN_SET = 150,
  parameter int WARN_CLR = 135,
  parameter int SHUT_SET = 181,
  parameter int SHUT_CLR = 155
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              warn,
  output logic              shut
);
  import pss_pkg::*;

  localparam logic [TEMP_W-1:0] W_SET = TEMP_W'(WARN_SET);
  localparam logic [TEMP_W-1:0] W_CLR = TEMP_W'(WARN_CLR);
  localparam logic [TEMP_W-1:0] S_SET = TEMP_W'(SHUT_SET);
  localparam logic [TEMP_W-1:0] S_CLR = TEMP_W'(SHUT_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn <= 1'b0;
      shut <= 1'b0;
    end else begin
      warn <= hyst_next(warn, temp_code >= W_SET, temp_code < W_CLR);
      shut <= hyst_next(shut, temp_code >= S_SET, temp_code < S_CLR);
    end
  end
endmodule

// File: rtl/pss_cal_ctrl.sv
module pss_cal_ctrl #(
  parameter int CAL_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_good,
  input  logic pin_en,
  input  logic shut,
  output logic cal_done
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_good || !pin_en) begin
      cnt      <= '0;
      cal_done <= 1'b0;
    end else if (shut) begin
      cnt      <= '0;            // abort a running interval, keep a finished one
    end else if (!cal_done) begin
      if (cnt == LAST) begin
        cnt      <= '0;
        cal_done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_stage_supervisor.sv
module pwr_stage_supervisor #(
  parameter int SUPPLY_W   = 10,
  parameter bit USE_FLAGS  = 1'b0,
  parameter int UV_SET     = 435,
  parameter int UV_CLR     = 415,
  parameter int TEMP_W     = 9,
  parameter int WARN_SET   = 150,
  parameter int WARN_CLR   = 135,
  parameter int SHUT_SET   = 181,
  parameter int SHUT_CLR   = 155,
  parameter int CAL_CYCLES = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SUPPLY_W-1:0] supply_code,
  input  logic                sup_above_rise,
  input  logic                sup_above_fall,
  input  logic                dis_n,
  input  logic [TEMP_W-1:0]   temp_code,
  output logic                seq_en,
  output logic                seq_start,
  output logic                cal_busy,
  output logic                therm_warn_n
);
  logic dis_q, good, warn, shut, cal_done, run_ok;

  always_ff @(posedge clk) begin
    if (rst) dis_q <= 1'b0;
    else     dis_q <= dis_n;
  end

  pss_uv_monitor #(
    .SUPPLY_W(SUPPLY_W), .USE_FLAGS(USE_FLAGS), .UV_SET(UV_SET), .UV_CLR(UV_CLR)
  ) u_uv (
    .clk(clk), .rst(rst), .supply_code(supply_code),
    .above_rise(sup_above_rise), .above_fall(sup_above_fall), .good(good)
  );

  pss_thermal_monitor #(
    .TEMP_W(TEMP_W), .WARN_SET(WARN_SET), .WARN_CLR(WARN_CLR),
    .SHUT_SET(SHUT_SET), .SHUT_CLR(SHUT_CLR)
  ) u_th (
    .clk(clk), .rst(rst), .temp_code(temp_code), .warn(warn), .shut(shut)
  );

  pss_cal_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst(rst), .supply_good(good), .pin_en(dis_q),
    .shut(shut), .cal_done(cal_done)
  );

  assign run_ok = good && dis_q && !shut;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_en       <= 1'b0;
      seq_start    <= 1'b0;
      cal_busy     <= 1'b0;
      therm_warn_n <= 1'b1;
    end else begin
      seq_en       <= run_ok && cal_done;
      seq_start    <= run_ok && cal_done && !seq_en;
      cal_busy     <= run_ok && !cal_done;
      therm_warn_n <= !warn;
    end
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int SUPPLY_W   = 10,
  parameter bit USE_FLAGS  = 1'b0,
  parameter int UV_CLR     = 415,
  parameter int TEMP_W     = 9,
  parameter int WARN_SET   = 150,
  parameter int WARN_CLR   = 135,
  parameter int SHUT_SET   = 181,
  parameter int CAL_CYCLES = 25
) (
  input logic                clk,
  input logic                rst,
  input logic [SUPPLY_W-1:0] supply_code,
  input logic                sup_above_fall,
  input logic                dis_n,
  input logic [TEMP_W-1:0]   temp_code,
  input logic                seq_en,
  input logic                seq_start,
  input logic                cal_busy,
  input logic                therm_warn_n
);
  localparam int RW = $clog2(CAL_CYCLES + 2);
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)           busy_run <= '0;
    else if (cal_busy) busy_run <= (busy_run == RW'(CAL_CYCLES + 1)) ? busy_run : busy_run + 1'b1;
    else               busy_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!seq_en && !seq_start && !cal_busy && therm_warn_n)); // R1
  AST_UV_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (USE_FLAGS ? !$past(sup_above_fall, 2) : ($past(supply_code, 2) < SUPPLY_W'(UV_CLR))) |-> !seq_en); // R2
  AST_PIN_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst) !$past(dis_n, 2) |-> !seq_en); // R3
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) cal_busy |-> !seq_en); // R4
  AST_CAL_NOT_LONG: assert property (@(posedge clk) disable iff (rst) busy_run <= RW'(CAL_CYCLES)); // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) seq_start |=> !seq_start); // R6
  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(seq_en) |-> seq_start); // R6
  AST_WARN_SETS: assert property (@(posedge clk) disable iff (rst)
    ($past(temp_code, 2) >= TEMP_W'(WARN_SET)) |-> !therm_warn_n); // R7
  AST_WARN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(temp_code, 2) < TEMP_W'(WARN_CLR)) |-> therm_warn_n); // R7
  AST_SHUT_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    ($past(temp_code, 2) >= TEMP_W'(SHUT_SET)) |-> !seq_en); // R8
endmodule

bind pwr_stage_supervisor pss_checker #(
  .SUPPLY_W(SUPPLY_W), .USE_FLAGS(USE_FLAGS), .UV_CLR(UV_CLR), .TEMP_W(TEMP_W),
  .WARN_SET(WARN_SET), .WARN_CLR(WARN_CLR), .SHUT_SET(SHUT_SET), .CAL_CYCLES(CAL_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .supply_code(supply_code), .sup_above_fall(sup_above_fall),
  .dis_n(dis_n), .temp_code(temp_code), .seq_en(seq_en), .seq_start(seq_start),
  .cal_busy(cal_busy), .therm_warn_n(therm_warn_n)
);

// File: tb/pwr_stage_supervisor_tb.sv
module pwr_stage_supervisor_tb;
  localparam int SW  = 10;
  localparam int TW  = 9;
  localparam int CAL = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] supply_code = SW'(500);
  logic sup_above_rise = 1'b1;
  logic sup_above_fall = 1'b1;
  logic dis_n = 1'b0;
  logic [TW-1:0] temp_code = TW'(25);
  logic seq_en, seq_start, cal_busy, therm_warn_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  pwr_stage_supervisor #(.SUPPLY_W(SW), .TEMP_W(TW), .CAL_CYCLES(CAL)) u_dut (
    .clk(clk), .rst(rst), .supply_code(supply_code), .sup_above_rise(sup_above_rise),
    .sup_above_fall(sup_above_fall), .dis_n(dis_n), .temp_code(temp_code),
    .seq_en(seq_en), .seq_start(seq_start), .cal_busy(cal_busy), .therm_warn_n(therm_warn_n)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // wait n rising edges, then sit at the following falling edge
  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bring_up();
    dis_n = 1'b0; supply_code = SW'(500); temp_code = TW'(25);
    settle(2);
    dis_n = 1'b1;
    settle(CAL + 2);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    settle(3);
    check("R1", "seq_en in reset", seq_en, 1'b0);
    check("R1", "seq_start in reset", seq_start, 1'b0);
    check("R1", "cal_busy in reset", cal_busy, 1'b0);
    check("R1", "therm_warn_n in reset", therm_warn_n, 1'b1);
    rst = 1'b0;
    settle(1);
    check("R1", "seq_en after reset", seq_en, 1'b0);
  endtask

  task automatic t_calibrate();
    dis_n = 1'b0; settle(2);
    check("R3", "seq_en with dis_n low", seq_en, 1'b0);
    check("R3", "cal_busy with dis_n low", cal_busy, 1'b0);
    dis_n = 1'b1;
    settle(1);
    check("R4", "cal_busy one edge after enable", cal_busy, 1'b0);
    settle(1);
    check("R4", "cal_busy starts", cal_busy, 1'b1);
    settle(CAL - 1);
    check("R4", "cal_busy last cycle", cal_busy, 1'b1);
    check("R4", "seq_en held during calibration", seq_en, 1'b0);
    settle(1);
    check("R4", "seq_en after calibration", seq_en, 1'b1);
    check("R4", "cal_busy cleared", cal_busy, 1'b0);
    check("R6", "seq_start pulse", seq_start, 1'b1);
    settle(1);
    check("R6", "seq_start single cycle", seq_start, 1'b0);
    check("R6", "seq_en stays", seq_en, 1'b1);
  endtask

  task automatic t_recal();
    dis_n = 1'b0; settle(2);
    check("R3", "disable drops seq_en", seq_en, 1'b0);
    dis_n = 1'b1; settle(CAL + 1);
    check("R5", "recalibration still busy", cal_busy, 1'b1);
    check("R5", "seq_en waits for recalibration", seq_en, 1'b0);
    settle(1);
    check("R5", "seq_en after recalibration", seq_en, 1'b1);
  endtask

  task automatic t_uv();
    bring_up();
    supply_code = SW'(420); settle(2);
    check("R2", "inside band keeps good", seq_en, 1'b1);
    supply_code = SW'(415); settle(2);
    check("R2", "at falling threshold keeps good", seq_en, 1'b1);
    supply_code = SW'(414); settle(2);
    check("R2", "below falling threshold locks", seq_en, 1'b0);
    supply_code = SW'(434); settle(2);
    check("R2", "inside band stays locked", seq_en, 1'b0);
    check("R2", "no calibration while locked", cal_busy, 1'b0);
    dis_n = 1'b0; settle(2); dis_n = 1'b1; settle(2);
    check("R2", "dis_n high ignored while locked", seq_en, 1'b0);
    supply_code = SW'(435); settle(2);
    check("R10", "supply return recalibrates", cal_busy, 1'b1);
    check("R10", "no enable before calibration", seq_en, 1'b0);
    settle(CAL);
    check("R10", "enable after recalibration", seq_en, 1'b1);
  endtask

  task automatic t_warn();
    bring_up();
    temp_code = TW'(149); settle(2);
    check("R7", "149 no warning", therm_warn_n, 1'b1);
    temp_code = TW'(150); settle(2);
    check("R7", "150 warns", therm_warn_n, 1'b0);
    check("R7", "warning keeps enable", seq_en, 1'b1);
    temp_code = TW'(135); settle(2);
    check("R7", "135 still warns", therm_warn_n, 1'b0);
    temp_code = TW'(134); settle(2);
    check("R7", "134 releases", therm_warn_n, 1'b1);
  endtask

  task automatic t_shutdown();
    bring_up();
    temp_code = TW'(180); settle(2);
    check("R8", "180 keeps running", seq_en, 1'b1);
    temp_code = TW'(181); settle(2);
    check("R8", "181 shuts down", seq_en, 1'b0);
    check("R7", "warning during shutdown", therm_warn_n, 1'b0);
    temp_code = TW'(155); settle(2);
    check("R8", "155 still shut down", seq_en, 1'b0);
    temp_code = TW'(154); settle(2);
    check("R10", "resume without calibration", seq_en, 1'b1);
    check("R10", "no calibration on resume", cal_busy, 1'b0);
    check("R10", "start pulse on resume", seq_start, 1'b1);
    settle(1);
    check("R6", "resume pulse single cycle", seq_start, 1'b0);
  endtask

  task automatic t_abort();
    dis_n = 1'b0; supply_code = SW'(500); temp_code = TW'(25); settle(2);
    dis_n = 1'b1; settle(12);
    check("R9", "calibrating before dropout", cal_busy, 1'b1);
    supply_code = SW'(400); settle(2);
    check("R9", "dropout aborts calibration", cal_busy, 1'b0);
    supply_code = SW'(500); settle(CAL + 1);
    check("R9", "full calibration after dropout", cal_busy, 1'b1);
    check("R9", "no early enable after dropout", seq_en, 1'b0);
    settle(1);
    check("R9", "enable after full calibration", seq_en, 1'b1);
    dis_n = 1'b0; settle(2); dis_n = 1'b1; settle(12);
    temp_code = TW'(200); settle(2);
    check("R9", "shutdown aborts calibration", cal_busy, 1'b0);
    temp_code = TW'(25); settle(CAL + 1);
    check("R9", "full calibration after shutdown", cal_busy, 1'b1);
    check("R9", "no early enable after shutdown", seq_en, 1'b0);
    settle(1);
    check("R9", "enable after calibration", seq_en, 1'b1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_reset();
    t_calibrate();
    t_recal();
    t_uv();
    t_warn();
    t_shutdown();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule